// File: doc/BRIEF.md
# Floating-Point Condition Predicate Evaluator

This block decides whether a floating-point conditional test is true. A conditional branch, set or trap unit presents a predicate code and the current floating-point status word. The block answers with one result bit, a flag for a predicate code that has no meaning, and the status word to write back. The predicate splits into three fields. One bit selects a test that signals on NaN or one that does not. One bit negates the test. Three bits pick one of eight base conditions over the negative, zero and NaN condition codes.

The returned status word has its exception byte cleared. A test that signals on NaN also sets the branch-unordered exception bit in that byte when the NaN code is set. A request is a single-cycle pulse on `req_i`. One clock later `valid_o` pulses and the outputs carry the answer. They hold that answer until the next request has been registered. Working out the branch target and raising the trap belong to the caller.

Top module: `fpcc_eval`

## Requirements
- R1: While `rst_n` is low at a clock edge, `valid_o`, `result_o` and `illegal_o` become 0 and `stat_o` becomes all zeros.
- R2: `valid_o` is high for exactly the one cycle after each cycle in which `req_i` is high. `result_o`, `illegal_o` and `stat_o` change only in the cycle after a request, and otherwise hold their last value.
- R3: Only `pred_i[5:0]` is used, so bits 7:6 have no effect. When `pred_i[5]` is 1 the predicate is illegal: `illegal_o`=1, `result_o`=0, and `stat_o` equals `stat_i` unchanged. Otherwise `illegal_o`=0.
- R4: The condition codes are N=`stat_i[27]`, Z=`stat_i[26]` and NaN=`stat_i[24]`. Bit 25 takes no part in any test. With `pred_i[3]`=0 the base condition `pred_i[2:0]` selects one of:
  - 0: false
  - 1: Z
  - 2: no NaN, no Z and no N
  - 3: Z, or neither NaN nor N
  - 4: N with neither NaN nor Z
  - 5: Z, or N without NaN
  - 6: neither NaN nor Z
  - 7: no NaN
- R5: When `pred_i[3]` is 1, the base condition is the bitwise inverse of `pred_i[2:0]`, and `result_o` is the inverse of that condition.
- R6: For a legal predicate, `stat_o` copies `stat_i` except the exception byte `stat_o[15:8]`, which is cleared apart from R7.
- R7: For a legal predicate, `stat_o[15]` (branch-unordered) is 1 exactly when `pred_i[4]` is 1 and NaN is set.
- R8: `pred_i[4]` does not change `result_o`. Predicates that differ only in bit 4 give the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Single-cycle evaluation request |
| pred_i | input | 8 | Predicate code; bits 5:0 used |
| stat_i | input | 32 | Current floating-point status word |
| valid_o | output | 1 | Pulses one cycle after a request |
| result_o | output | 1 | Predicate outcome |
| illegal_o | output | 1 | Predicate code out of range |
| stat_o | output | 32 | Status word to write back |

## Verification
The hardest case to reach from the ports is a negated predicate that signals on NaN and meets a status word that already has exception bits set. All three effects then show at once: the inverted result, the cleared exception byte and the newly set branch-unordered bit. The stimulus covers this by sweeping all 64 six-bit predicate codes against all 16 combinations of the four condition-code bits, with every exception bit preset to 1. Further requests set the unused high predicate bits, and back-to-back requests check that the outputs are replaced one cycle after each request and hold while the bench is idle.

// File: rtl/fpcc_pkg.sv
// Shared types and status-word bit positions for the condition evaluator.
// Assumes a 32-bit status word with codes in bits 27:24 and exceptions in 15:8.
package fpcc_pkg;
    localparam int STAT_W   = 32;
    localparam int CC_N     = 27;
    localparam int CC_Z     = 26;
    localparam int CC_NAN   = 24;
    localparam int EXC_LO   = 8;
    localparam int EXC_HI   = 15;
    localparam int BSUN_BIT = 15;

    typedef enum logic [2:0] {
        C_FALSE = 3'd0, C_EQ = 3'd1, C_GT = 3'd2, C_GE = 3'd3,
        C_LT    = 3'd4, C_LE = 3'd5, C_GL = 3'd6, C_OR = 3'd7
    } base_e;

    typedef struct packed {
        logic  illegal;
        logic  nan_sig;
        logic  negate;
        base_e base;
    } pred_dec_t;
endpackage

// File: rtl/fpcc_decode.sv
// Splits the six-bit predicate into class, negate and base-condition fields.
// Assumes the caller has already dropped every predicate bit above bit 5.
module fpcc_decode
    import fpcc_pkg::*;
(
    input  logic [5:0] pred,
    output pred_dec_t  dec
);
    // Field extraction: a negated test folds onto its complementary base code.
    always_comb begin
        dec.illegal = pred[5];
        dec.nan_sig = pred[4];
        dec.negate  = pred[3];
        dec.base    = base_e'(pred[3] ? ~pred[2:0] : pred[2:0]);
    end
endmodule

// File: rtl/fpcc_cond.sv
// Evaluates one base condition over the negative, zero and NaN codes.
// Assumes the codes come straight from the status word (no infinity input).
module fpcc_cond
    import fpcc_pkg::*;
(
    input  base_e base,
    input  logic  n,
    input  logic  z,
    input  logic  nan,
    output logic  hit
);
    // Condition table for the eight base codes.
    always_comb begin
        unique case (base)
            C_FALSE: hit = 1'b0;
            C_EQ:    hit = z;
            C_GT:    hit = !(nan || z || n);
            C_GE:    hit = z || !(nan || n);
            C_LT:    hit = n && !nan && !z;
            C_LE:    hit = z || (n && !nan);
            C_GL:    hit = !(nan || z);
            C_OR:    hit = !nan;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpcc_eval.sv
// Registered floating-point condition predicate evaluator.
// Takes a one-cycle request with predicate and status word. Answers one cycle
// later and holds the answer until the next request.
// Assumes PRED_W >= 6 and the status-word layout of fpcc_pkg.
module fpcc_eval
    import fpcc_pkg::*;
#(
    parameter int PRED_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [PRED_W-1:0] pred_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic              valid_o,
    output logic              result_o,
    output logic              illegal_o,
    output logic [STAT_W-1:0] stat_o
);
    localparam int USED_W = 6;

    pred_dec_t         dec;
    logic              raw_hit;
    logic              truth;
    logic              bsun;
    logic [STAT_W-1:0] stat_nx;
    logic              unused_hi;

    assign unused_hi = ^pred_i[PRED_W-1:USED_W];

    fpcc_decode u_dec (
        .pred (pred_i[USED_W-1:0]),
        .dec  (dec)
    );

    fpcc_cond u_cond (
        .base (dec.base),
        .n    (stat_i[CC_N]),
        .z    (stat_i[CC_Z]),
        .nan  (stat_i[CC_NAN]),
        .hit  (raw_hit)
    );

    // Final outcome and branch-unordered decision.
    always_comb begin
        truth = raw_hit ^ dec.negate;
        bsun  = dec.nan_sig & stat_i[CC_NAN];
    end

    // Status rebuild: the exception byte is cleared except the unordered bit.
    for (genvar i = 0; i < STAT_W; i++) begin : g_stat
        if (i == BSUN_BIT) begin : g_bsun
            assign stat_nx[i] = bsun;
        end else if (i >= EXC_LO && i <= EXC_HI) begin : g_clr
            assign stat_nx[i] = 1'b0;
        end else begin : g_keep
            assign stat_nx[i] = stat_i[i];
        end
    end

    // Output registers: loaded on a request, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o   <= 1'b0;
            result_o  <= 1'b0;
            illegal_o <= 1'b0;
            stat_o    <= '0;
        end else begin
            valid_o <= req_i;
            if (req_i) begin
                illegal_o <= dec.illegal;
                result_o  <= dec.illegal ? 1'b0 : truth;
                stat_o    <= dec.illegal ? stat_i : stat_nx;
            end
        end
    end

    // R2: a request is answered by valid in the next cycle.
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);

    // R2: without a request the outputs hold.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!valid_o && $stable(result_o) && $stable(illegal_o) && $stable(stat_o)));

    // R3: an illegal code gives a zero result and an untouched status word.
    p_illegal_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && pred_i[5]) |=> (illegal_o && !result_o && stat_o == $past(stat_i)));

    // R6: after a legal request the low exception bits are clear.
    p_exc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !illegal_o) |-> (stat_o[EXC_HI-1:EXC_LO] == '0));

    // R6: the bits above the exception byte pass through.
    p_upper_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (stat_o[STAT_W-1:EXC_HI+1] == $past(stat_i[STAT_W-1:EXC_HI+1])));

    // R7: a test that does not signal on NaN never sets branch-unordered.
    p_no_bsun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !pred_i[5] && !pred_i[4]) |=> !stat_o[BSUN_BIT]);
endmodule

// File: tb/fpcc_eval_bench.sv
// Scoreboard bench: the driver queues expected answers and the monitor compares them.
module fpcc_eval_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [7:0]  pred_i = '0;
    logic [31:0] stat_i = '0;
    logic        valid_o, result_o, illegal_o;
    logic [31:0] stat_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0]  pred;
        logic        res;
        logic        ill;
        logic [31:0] stat;
    } item_t;

    item_t exp_q[$];
    item_t last;
    bit    have_last = 1'b0;

    always #2 clk = ~clk;

    fpcc_eval u_fpcc_eval (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .pred_i(pred_i), .stat_i(stat_i),
        .valid_o(valid_o), .result_o(result_o), .illegal_o(illegal_o), .stat_o(stat_o)
    );

    // Expected answer, written from the requirement text.
    function automatic item_t model(logic [7:0] p, logic [31:0] s);
        item_t it;
        logic n, z, nan, c;
        logic [2:0] b;
        n = s[27]; z = s[26]; nan = s[24];
        it.pred = p;
        if (p[5]) begin
            it.ill = 1'b1; it.res = 1'b0; it.stat = s;
        end else begin
            b = p[3] ? ~p[2:0] : p[2:0];
            case (b)
                3'd0: c = 1'b0;
                3'd1: c = z;
                3'd2: c = !nan && !z && !n;
                3'd3: c = z || (!nan && !n);
                3'd4: c = n && !nan && !z;
                3'd5: c = z || (n && !nan);
                3'd6: c = !nan && !z;
                default: c = !nan;
            endcase
            it.ill = 1'b0;
            it.res = c ^ p[3];
            it.stat = s;
            it.stat[15:8] = 8'h00;
            it.stat[15] = p[4] & nan;
        end
        return it;
    endfunction

    // Issue one request at a falling edge; then idle for gap cycles.
    task automatic send(logic [7:0] p, logic [31:0] s, int gap);
        req_i = 1'b1; pred_i = p; stat_i = s;
        exp_q.push_back(model(p, s));
        @(negedge clk);
        req_i = 1'b0;
        pred_i = $urandom; stat_i = $urandom;
        repeat (gap) @(negedge clk);
    endtask

    // Monitor: compares answers on valid and checks the hold between requests.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (valid_o) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2: valid without request, actual=1 expected=0");
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    checks++;
                    if (illegal_o !== e.ill) begin
                        errors++;
                        $display("FAIL R3: pred=%h illegal actual=%b expected=%b", e.pred, illegal_o, e.ill);
                    end
                    checks++;
                    if (result_o !== e.res) begin
                        errors++;
                        if (e.ill) $display("FAIL R3: pred=%h result actual=%b expected=%b", e.pred, result_o, e.res);
                        else if (e.pred[3]) $display("FAIL R5: pred=%h result actual=%b expected=%b", e.pred, result_o, e.res);
                        else if (e.pred[4]) $display("FAIL R8: pred=%h result actual=%b expected=%b", e.pred, result_o, e.res);
                        else $display("FAIL R4: pred=%h result actual=%b expected=%b", e.pred, result_o, e.res);
                    end
                    checks++;
                    if (stat_o !== e.stat) begin
                        errors++;
                        if (e.ill) $display("FAIL R3: pred=%h stat actual=%h expected=%h", e.pred, stat_o, e.stat);
                        else if (stat_o[15] !== e.stat[15]) $display("FAIL R7: pred=%h stat actual=%h expected=%h", e.pred, stat_o, e.stat);
                        else $display("FAIL R6: pred=%h stat actual=%h expected=%h", e.pred, stat_o, e.stat);
                    end
                    last = e; have_last = 1'b1;
                end
            end else if (have_last) begin
                checks++;
                if (result_o !== last.res || illegal_o !== last.ill || stat_o !== last.stat) begin
                    errors++;
                    $display("FAIL R2: hold actual=%b/%b/%h expected=%b/%b/%h",
                             result_o, illegal_o, stat_o, last.res, last.ill, last.stat);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired, actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        checks++;
        if (valid_o !== 1'b0 || result_o !== 1'b0 || illegal_o !== 1'b0 || stat_o !== 32'h0) begin
            errors++;
            $display("FAIL R1: reset actual=%b/%b/%b/%h expected=0/0/0/0", valid_o, result_o, illegal_o, stat_o);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5 R7 R8 R6: sweep all six-bit codes against all condition-code sets.
        for (int p = 0; p < 64; p++) begin
            for (int cc = 0; cc < 16; cc++) begin
                send(8'(p), {4'h5, 4'(cc), 8'hA3, 8'hFF, 8'h6C}, (cc == 3) ? 2 : 0);
            end
        end

        // R3: the high predicate bits are ignored, legal and illegal codes alike.
        send(8'hC2, 32'h0000_FF00, 1);
        send(8'h43, 32'h0800_FF00, 0);
        send(8'h9D, 32'h0100_8000, 1);
        send(8'hE0, 32'hDEAD_BEEF, 3);
        send(8'h3F, 32'h0F00_FFFF, 0);

        // R7: a NaN with a signalling test, then a quiet test, back to back.
        send(8'h11, 32'h0100_0000, 0);
        send(8'h01, 32'h0100_0000, 4);

        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2: pending answers actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule